// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for every beat of a memory burst. A one-cycle start pulse captures a start column, a length code and an ordering bit. The first column then appears on the registered output. Each advance pulse moves the output to the column of the next beat. For a fixed length, the addresses stay inside the naturally aligned group of columns that contains the start column. Only the low address bits move, either counting upward or following an XOR pattern. A full-page burst counts through the whole page, wraps past the top column, and keeps running until it is stopped.

The block sits next to a memory command sequencer. That sequencer issues start when it opens a column access, pulses advance once per transferred word, and watches done to learn that the burst has closed. The terminate input ends any burst early, and it is the only way to close a full-page burst.

Top module: `burst_col_gen`

## Requirements
- R1: In the cycle after a cycle with rst high, busy is 0, done is 0 and col is 0.
- R2: A start pulse with terminate low loads start_col, len_code and interleave. In the next cycle col equals start_col and busy is 1. The inputs sampled at start are then held for the whole burst, whatever the inputs do later.
- R3: len_code values 0, 1, 2 and 3 select fixed bursts of 1, 2, 4 and 8 beats. The start presents beat 0. Each advance while busy presents the next beat. The advance that consumes the last beat drops busy and pulses done in the following cycle, and col keeps the last beat's column.
- R4: In a fixed burst of N beats, every column presented has the same bits above the low log2(N) bits as the start column.
- R5: In sequential order (interleave = 0), beat k has low log2(N) bits equal to (start + k) mod N.
- R6: In interleaved order (interleave = 1), beat k has low log2(N) bits equal to the start column's low bits XOR k. For example, 8 beats from start 2 give 2, 3, 0, 1, 6, 7, 4, 5.
- R7: A len_code with bit 2 set (7 is the intended value) selects full page. The interleave bit is ignored. Each advance adds 1 to the whole column, wrapping from the top column of the page to 0, and no advance ever ends the burst.
- R8: terminate has highest priority. While busy, it drops busy and pulses done in the next cycle, leaving col unchanged even if start or advance is high in the same cycle. A start together with terminate is ignored.
- R9: done is a single-cycle pulse. While idle, advance or terminate without start leaves col, busy and done unchanged (done stays 0).
- R10: A start while a burst is busy abandons that burst without a done pulse and begins the new one, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst with the values on start_col, len_code and interleave |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code: 0..3 for 1/2/4/8 beats, bit 2 set for full page |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects sequential ordering |
| advance | input | 1 | Move to the next beat of the current burst |
| terminate | input | 1 | End the current burst at once |
| col | output | COL_W | Registered column address of the current beat |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse when a burst ends |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge after reset. They also assume that len_code carries a defined value whenever start is sampled. The bench meets these assumptions by changing its inputs only on falling edges and by driving every input to a defined level at all times. Between starts it scrambles start_col, len_code and interleave, so that the hold of the captured burst settings is exercised. Random starts, gaps between advances and early terminations are confined to the points where the bench's own model knows what the outputs should be.

// File: rtl/burst_col_pkg.sv
`timescale 1ns/1ps
package burst_col_pkg;
  // Beat counter width covers the longest fixed burst (8 beats).
  localparam int BEAT_W = 3;

  typedef struct packed {
    logic              full_page;
    logic              interleave;
    logic [BEAT_W-1:0] mask;   // burst length minus one
  } burst_mode_t;
endpackage

// File: rtl/burst_mode_dec.sv
`timescale 1ns/1ps
module burst_mode_dec
  import burst_col_pkg::*;
(
  input  logic [2:0]  len_code,
  input  logic        interleave_req,
  output burst_mode_t mode
);
  always_comb begin
    mode.full_page  = len_code[2];
    // Full page supports only the upward count.
    mode.interleave = interleave_req & ~len_code[2];
    unique case (len_code[1:0])
      2'd0:    mode.mask = BEAT_W'(0);
      2'd1:    mode.mask = BEAT_W'(1);
      2'd2:    mode.mask = BEAT_W'(3);
      default: mode.mask = BEAT_W'(7);
    endcase
    if (len_code[2]) mode.mask = '1;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
module burst_beat_ctr
  import burst_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [BEAT_W-1:0] mask,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (rst || clr) beat <= '0;
    else if (inc)   beat <= beat + 1'b1;
  end

  assign last = (beat == mask);

  // R3: the beat index never leaves the range of the selected length.
  p_beat_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (beat & ~mask) == '0);
endmodule

// File: rtl/burst_addr_mix.sv
`timescale 1ns/1ps
module burst_addr_mix
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] beat,
  input  burst_mode_t       mode,
  output logic [COL_W-1:0]  col
);
  localparam int HI_W = COL_W - BEAT_W;

  logic [BEAT_W-1:0] low_seq, low_xor, low_sel;

  always_comb begin
    low_seq = base[BEAT_W-1:0] + beat;
    low_xor = base[BEAT_W-1:0] ^ beat;
    low_sel = mode.interleave ? low_xor : low_seq;
    col     = {base[COL_W-1:BEAT_W],
               (base[BEAT_W-1:0] & ~mode.mask) | (low_sel & mode.mask)};
  end

  // R6: with interleave the moving bits differ from the base only by the beat.
  always_comb begin
    if (mode.interleave && !mode.full_page)
      a_xor_r6: assert (((col[BEAT_W-1:0] ^ base[BEAT_W-1:0]) & ~beat) == '0);
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             advance,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             done
);
  burst_mode_t       new_mode, mode_q;
  logic [COL_W-1:0]  base_q, col_q, next_fixed, next_col;
  logic              busy_q, done_q;
  logic [BEAT_W-1:0] beat;
  logic              last;
  logic              beat_clr, beat_inc;

  burst_mode_dec u_dec (
    .len_code       (len_code),
    .interleave_req (interleave),
    .mode           (new_mode)
  );

  assign beat_clr = start & ~terminate;
  assign beat_inc = advance & busy_q & ~start & ~terminate
                  & ~mode_q.full_page & ~last;

  burst_beat_ctr u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (beat_clr),
    .inc  (beat_inc),
    .mask (mode_q.mask),
    .beat (beat),
    .last (last)
  );

  burst_addr_mix #(.COL_W(COL_W)) u_mix (
    .base (base_q),
    .beat (beat + 1'b1),
    .mode (mode_q),
    .col  (next_fixed)
  );

  assign next_col = mode_q.full_page ? col_q + 1'b1 : next_fixed;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      col_q  <= '0;
      base_q <= '0;
      mode_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (terminate) begin
        if (busy_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        base_q <= start_col;
        col_q  <= start_col;
        mode_q <= new_mode;
      end else if (advance && busy_q) begin
        if (!mode_q.full_page && last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          col_q <= next_col;
        end
      end
    end
  end

  assign col  = col_q;
  assign busy = busy_q;
  assign done = done_q;

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy_q && !done_q && col_q == '0));
  // R2
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !terminate) |=> (busy_q && col_q == $past(start_col)));
  // R3
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R4
  p_in_block_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !mode_q.full_page) |->
      (col_q[COL_W-1:BEAT_W] == base_q[COL_W-1:BEAT_W] &&
       ((col_q[BEAT_W-1:0] ^ base_q[BEAT_W-1:0]) & ~mode_q.mask) == '0));
  // R7
  p_page_step_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mode_q.full_page && advance && !start && !terminate)
      |=> (busy_q && col_q == $past(col_q) + 1'b1));
  // R8
  p_term_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && terminate) |=> (!busy_q && done_q && $stable(col_q)));
  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && (!start || terminate)) |=> ($stable(col_q) && !busy_q && !done_q));
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1, start = 1'b0, interleave = 1'b0;
  logic             advance = 1'b0, terminate = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = 3'd0;
  logic [COL_W-1:0] col;
  logic             busy, done;

  int n_chk = 0, n_fail = 0;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .advance(advance),
    .terminate(terminate), .col(col), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int blen(input int code);
    return (code >= 4) ? PAGE : (1 << code);
  endfunction

  function automatic int exp_col(input int s, input int k, input int code, input bit il);
    int n, hi, lo;
    if (code >= 4) return (s + k) % PAGE;
    n  = blen(code);
    hi = s - (s % n);
    lo = il ? ((s % n) ^ k) : ((s + k) % n);
    return hi + lo;
  endfunction

  task automatic scramble();
    start_col  = COL_W'($urandom);
    len_code   = 3'($urandom);
    interleave = 1'($urandom);
  endtask

  task automatic begin_burst(input int s, input int code, input bit il);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); len_code = 3'(code); interleave = il;
    @(negedge clk);
    start = 1'b0; scramble();
    chk(busy === 1'b1 && int'(col) == s, "R2 load", int'(col), s);
  endtask

  task automatic pulse_adv();
    @(negedge clk); advance = 1'b1;
    @(negedge clk); advance = 1'b0;
  endtask

  task automatic run_fixed(input int s, input int code, input bit il, input bit gaps);
    int n = blen(code);
    begin_burst(s, code, il);
    for (int k = 1; k <= n; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        int held = int'(col);
        repeat (1 + $urandom % 3) @(negedge clk);
        chk(int'(col) == held && busy, "R5 hold without advance", int'(col), held);
      end
      pulse_adv();
      if (k < n) begin
        int e = exp_col(s, k, code, il);
        chk(int'(col) == e && busy, il ? "R6 xor order" : "R5 seq order", int'(col), e);
        chk((int'(col) / n) == (s / n), "R4 block", int'(col) / n, s / n);
      end else begin
        chk(!busy && done, "R3 end after N beats", {busy, done}, 1);
        chk(int'(col) == exp_col(s, n - 1, code, il), "R3 col holds last",
            int'(col), exp_col(s, n - 1, code, il));
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", done, 0);
  endtask

  task automatic do_term();
    @(negedge clk); terminate = 1'b1;
    @(negedge clk); terminate = 1'b0;
  endtask

  task automatic run_page(input int s, input int code, input bit il, input int nadv);
    begin_burst(s, code, il);
    for (int k = 1; k <= nadv; k++) begin
      pulse_adv();
      chk(int'(col) == exp_col(s, k, code, il) && busy, "R7 page step",
          int'(col), exp_col(s, k, code, il));
    end
    do_term();
    chk(!busy && done, "R8 terminate page", {busy, done}, 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && col == '0, "R1 reset state", int'(col), 0);

    // R9: idle advance and terminate do nothing
    @(negedge clk); advance = 1'b1;
    @(negedge clk); advance = 1'b0; terminate = 1'b1;
    @(negedge clk); terminate = 1'b0;
    chk(!busy && !done && col == '0, "R9 idle ignore", int'(col), 0);

    // R6: directed 8-beat xor order from start 2 (block base 160)
    begin
      int seq [8] = '{2, 3, 0, 1, 6, 7, 4, 5};
      begin_burst(162, 3, 1'b1);
      for (int k = 1; k < 8; k++) begin
        pulse_adv();
        chk(int'(col) == 160 + seq[k], "R6 directed xor", int'(col), 160 + seq[k]);
      end
      pulse_adv();
      chk(!busy && done, "R3 end 8", {busy, done}, 1);
    end

    // R7: page wrap, interleave ignored
    run_page(PAGE - 2, 7, 1'b1, 4);

    // R3: length 1
    run_fixed(77, 0, 1'b0, 1'b0);

    // R8: terminate mid fixed burst
    begin_burst(5, 3, 1'b0);
    pulse_adv(); pulse_adv();
    do_term();
    chk(!busy && done && int'(col) == 7, "R8 terminate fixed", int'(col), 7);

    // R8: terminate with start and advance while busy
    begin_burst(40, 2, 1'b0);
    @(negedge clk);
    terminate = 1'b1; start = 1'b1; advance = 1'b1; start_col = 9'd300;
    @(negedge clk);
    terminate = 1'b0; start = 1'b0; advance = 1'b0;
    chk(!busy && done && int'(col) == 40, "R8 priority", int'(col), 40);
    // R8: start with terminate while idle ignored
    @(negedge clk);
    terminate = 1'b1; start = 1'b1; start_col = 9'd301;
    @(negedge clk);
    terminate = 1'b0; start = 1'b0;
    chk(!busy && !done && int'(col) == 40, "R8 start ignored", int'(col), 40);

    // R10: restart while busy
    begin_burst(20, 2, 1'b0);
    pulse_adv();
    run_fixed(41, 1, 1'b0, 1'b0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      int code = $urandom % 8;
      int s    = $urandom % PAGE;
      bit il   = 1'($urandom);
      if (code >= 4) run_page(s, code, il, 1 + $urandom % 30);
      else           run_fixed(s, code, il, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule